// File: doc/BRIEF.md
# Receive FIFO Error Status Register

This block is the status register of a serial receiver whose received bytes wait in a 16-entry FIFO. The FIFO tells the block about every push, and each push carries a parity-error tag and a framing-error tag. The block keeps a shadow copy of those tags. From that copy it reports how many entries now held in the FIFO carry each kind of error. It also reports the tags of the entry at the head of the FIFO.

The same 16-bit word holds six sticky event flags. Hardware pulses set the flags. Software clears a flag in two steps: it first reads the flag while the flag is 1, then writes 0 to that bit. A flag that software has never seen set cannot be cleared, and no write can set a flag. The error-summary flag also sets by itself whenever an entry with either error enters the FIFO.

Top module: `rxfifo_err_status`

## Requirements
- R1: After reset the status word reads 0x0060. Bit 6 (transmit-end) and bit 5 (transmit-room) are 1, and every other bit is 0.
- R2: Bits 15:12 give the number of entries held in the FIFO that carry a parity tag. Bits 11:8 give the same count for framing tags. Each count changes in the cycle after the push or pop edge that causes the change.
- R3: A count is 4 bits wide, so when all 16 held entries carry the tag, the field reads 0.
- R4: A push while the FIFO is full and not popping is ignored. A pop while the FIFO is empty is ignored. A push and a pop in the same cycle with the same tag leave the count unchanged.
- R5: Bit 3 shows the framing tag and bit 2 shows the parity tag of the head entry. Both read 0 when the FIFO is empty.
- R6: Writing 1 to any bit never sets a flag. The flag bits are 7 (error summary), 6, 5, 4 (break), 1 (receive-data-full) and 0 (data-ready).
- R7: Writing 0 to a flag bit clears the flag only if a status read returned that flag as 1 after the flag was last set. Otherwise the write has no effect.
- R8: Writes to bits 15:8, bit 3 and bit 2 are ignored.
- R9: A set pulse in the same cycle as a valid clearing write leaves the flag at 1. A set pulse that arrives after the read cancels that read, so a later write of 0 does not clear the flag.
- R10: An accepted push with either error tag sets the error-summary flag, bit 7.
- R11: A pulse on flag_set[i] sets its flag in the next cycle. Index 0 is data-ready, 1 receive-data-full, 2 break, 3 transmit-room, 4 transmit-end, 5 error summary.
- R12: Reads and writes only take effect when reg_addr equals STATUS_ADDR (default 4). At any other address reg_rdata is 0, and accesses neither arm nor clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe; arms the clear of every flag currently 1 |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Status word when selected, else 0 |
| fifo_push | input | 1 | Entry pushed into the receive FIFO |
| fifo_push_perr | input | 1 | Parity tag of the pushed entry |
| fifo_push_ferr | input | 1 | Framing tag of the pushed entry |
| fifo_pop | input | 1 | Head entry removed from the FIFO |
| flag_set | input | 6 | Hardware set pulses, one per flag |

## Verification
The bench fills the FIFO with 16 parity-tagged entries. A design that keeps the count saturated, or one bit too wide, would then show 15 or a wrong field instead of 0. It pushes into a full FIFO and pops an empty one, which catches counts that run past the real occupancy. It also tries to clear a flag without reading it first, clears a flag in the same cycle that its set pulse arrives, and sets a flag again between the read and the write. Each of these exposes a clear handshake that loses or wrongly keeps the read-while-set state. Constant compares against a bench model of the tag queue and flags catch head tags that leak out of an empty FIFO, and accesses that take effect at a foreign address.

// File: rtl/rxfs_pkg.sv
package rxfs_pkg;
    localparam int NFLAG   = 6;
    localparam int FL_DR   = 0;
    localparam int FL_RDF  = 1;
    localparam int FL_BRK  = 2;
    localparam int FL_TDFE = 3;
    localparam int FL_TEND = 4;
    localparam int FL_ER   = 5;
    localparam int WORD_W  = 16;
    localparam int FIELD_W = 4;
    // Reset value per flag index: transmit-room and transmit-end start at 1.
    localparam logic [NFLAG-1:0] FLAG_RESET = 6'b011000;

    // Status-word bit that carries flag index i.
    function automatic int flag_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/rxfs_tag_fifo.sv
module rxfs_tag_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             push_perr_i,
    input  logic             push_ferr_i,
    input  logic             pop_i,
    output logic             push_ok_o,
    output logic [CNT_W-1:0] cnt_perr_o,
    output logic [CNT_W-1:0] cnt_ferr_o,
    output logic [CNT_W-1:0] fill_o,
    output logic             head_perr_o,
    output logic             head_ferr_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] fill;
        logic [CNT_W-1:0] cnt_p;
        logic [CNT_W-1:0] cnt_f;
        logic [DEPTH-1:0] tag_p;
        logic [DEPTH-1:0] tag_f;
    } tq_t;

    tq_t  s_d, s_q;
    logic pop_ok, push_ok, hp, hf, not_empty;

    always_comb begin
        s_d       = s_q;
        not_empty = (s_q.fill != '0);
        pop_ok    = pop_i && not_empty;
        push_ok   = push_i && ((s_q.fill != CNT_W'(DEPTH)) || pop_ok);
        hp        = s_q.tag_p[s_q.rd_ptr];
        hf        = s_q.tag_f[s_q.rd_ptr];
        if (push_ok) begin
            s_d.tag_p[s_q.wr_ptr] = push_perr_i;
            s_d.tag_f[s_q.wr_ptr] = push_ferr_i;
            s_d.wr_ptr            = s_q.wr_ptr + PTR_W'(1);
        end
        if (pop_ok) begin
            s_d.rd_ptr = s_q.rd_ptr + PTR_W'(1);
        end
        s_d.fill  = s_q.fill + CNT_W'(push_ok) - CNT_W'(pop_ok);
        s_d.cnt_p = s_q.cnt_p + CNT_W'(push_ok && push_perr_i) - CNT_W'(pop_ok && hp);
        s_d.cnt_f = s_q.cnt_f + CNT_W'(push_ok && push_ferr_i) - CNT_W'(pop_ok && hf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign push_ok_o   = push_ok;
    assign cnt_perr_o  = s_q.cnt_p;
    assign cnt_ferr_o  = s_q.cnt_f;
    assign fill_o      = s_q.fill;
    assign head_perr_o = not_empty & hp;
    assign head_ferr_o = not_empty & hf;
endmodule

// File: rtl/rxfs_flag_bank.sv
module rxfs_flag_bank #(
    parameter int NF = 6,
    parameter logic [NF-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [NF-1:0] wzero_i,
    output logic [NF-1:0] flag_o
);
    typedef struct packed {
        logic [NF-1:0] flag;
        logic [NF-1:0] seen;
    } fb_t;

    fb_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NF; i++) begin
            // Clear only through a write of 0 after a read that returned 1.
            s_d.flag[i] = set_i[i] | (s_q.flag[i] & ~(wr_i & wzero_i[i] & s_q.seen[i]));
            if (set_i[i] || !s_d.flag[i])
                s_d.seen[i] = 1'b0;
            else if (rd_i && s_q.flag[i])
                s_d.seen[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.flag <= RST_VAL;
            s_q.seen <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o = s_q.flag;
endmodule

// File: rtl/rxfifo_err_status.sv
module rxfifo_err_status
    import rxfs_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STATUS_ADDR = 4,
    parameter int DEPTH       = 16,
    localparam int CNT_W      = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              fifo_push,
    input  logic              fifo_push_perr,
    input  logic              fifo_push_ferr,
    input  logic              fifo_pop,
    input  logic [5:0]        flag_set
);
    logic             sel, push_ok, head_p, head_f;
    logic [CNT_W-1:0] cnt_p, cnt_f, fill_w;
    logic [NFLAG-1:0] wzero, set_all, flags;
    logic [15:0]      stat_w;

    assign sel = (reg_addr == ADDR_W'(STATUS_ADDR));

    rxfs_tag_fifo #(.DEPTH(DEPTH)) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (fifo_push),
        .push_perr_i (fifo_push_perr),
        .push_ferr_i (fifo_push_ferr),
        .pop_i       (fifo_pop),
        .push_ok_o   (push_ok),
        .cnt_perr_o  (cnt_p),
        .cnt_ferr_o  (cnt_f),
        .fill_o      (fill_w),
        .head_perr_o (head_p),
        .head_ferr_o (head_f)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_wz
        assign wzero[g] = ~reg_wdata[flag_pos(g)];
    end

    assign set_all = flag_set | (NFLAG'(push_ok & (fifo_push_perr | fifo_push_ferr)) << FL_ER);

    rxfs_flag_bank #(.NF(NFLAG), .RST_VAL(FLAG_RESET)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_all),
        .rd_i    (reg_rd & sel),
        .wr_i    (reg_wr & sel),
        .wzero_i (wzero),
        .flag_o  (flags)
    );

    always_comb begin
        stat_w        = '0;
        stat_w[15:12] = cnt_p[FIELD_W-1:0];
        stat_w[11:8]  = cnt_f[FIELD_W-1:0];
        stat_w[3]     = head_f;
        stat_w[2]     = head_p;
        for (int i = 0; i < NFLAG; i++) stat_w[flag_pos(i)] = flags[i];
    end

    assign reg_rdata = sel ? stat_w : 16'h0000;
endmodule

// File: rtl/rxfs_checker.sv
module rxfs_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [15:0]      stat_i,
    input logic [CNT_W-1:0] fill_i,
    input logic [5:0]       flag_set_i,
    input logic             push_i,
    input logic             pop_i,
    input logic             perr_i,
    input logic             ferr_i
);
    function automatic logic [5:0] fbits(input logic [15:0] w);
        return {w[7], w[6], w[5], w[4], w[1], w[0]};
    endfunction

    a_r11_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_set_i) |=> ((fbits(stat_i) & $past(flag_set_i)) == $past(flag_set_i)));

    a_r6_no_write_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set_i == 6'd0 && !(push_i && (perr_i || ferr_i)))
        |=> ((fbits(stat_i) & ~$past(fbits(stat_i))) == 6'd0));

    a_r2_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> ($stable(stat_i[15:8]) && $stable(stat_i[3:2])));

    a_r5_empty_head: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i == '0) |-> (stat_i[3:2] == 2'b00));

    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i <= CNT_W'(DEPTH));
endmodule

bind rxfifo_err_status rxfs_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_i     (stat_w),
    .fill_i     (fill_w),
    .flag_set_i (flag_set),
    .push_i     (fifo_push),
    .pop_i      (fifo_pop),
    .perr_i     (fifo_push_perr),
    .ferr_i     (fifo_push_ferr)
);

// File: tb/rxfifo_err_status_test.sv
`timescale 1ns/1ps
module rxfifo_err_status_test;
    localparam int ST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'(ST);
    logic        reg_rd = 0, reg_wr = 0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        fifo_push = 0, fifo_push_perr = 0, fifo_push_ferr = 0, fifo_pop = 0;
    logic [5:0]  flag_set = '0;

    int checks = 0, errors = 0;
    bit done = 0;

    bit   mp[16], mf[16];
    int   head = 0, fill = 0;
    logic [5:0] fl = 6'b011000, sn = '0;

    always #5 clk = ~clk;

    rxfifo_err_status uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_push(fifo_push), .fifo_push_perr(fifo_push_perr),
        .fifo_push_ferr(fifo_push_ferr), .fifo_pop(fifo_pop), .flag_set(flag_set));

    function automatic int fpos(input int i);
        int p[6] = '{0, 1, 4, 5, 6, 7};
        return p[i];
    endfunction

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        int cp = 0, cf = 0;
        for (int k = 0; k < fill; k++) begin
            cp += mp[(head + k) % 16];
            cf += mf[(head + k) % 16];
        end
        w[15:12] = 4'(cp % 16);
        w[11:8]  = 4'(cf % 16);
        if (fill > 0) begin
            w[3] = mf[head];
            w[2] = mp[head];
        end
        for (int i = 0; i < 6; i++) w[fpos(i)] = fl[i];
        return w;
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model(input bit pu, input bit pp, input bit pf, input bit po,
                         input logic [5:0] hs, input bit rd, input bit wr,
                         input logic [15:0] wd, input bit sel);
        bit apo = po && fill > 0;
        bit apu = pu && (fill < 16 || apo);
        logic [5:0] setv = hs;
        logic [5:0] nfl;
        if (apu && (pp || pf)) setv[5] = 1'b1;
        for (int i = 0; i < 6; i++) begin
            bit clr = sel && wr && !wd[fpos(i)] && sn[i];
            nfl[i] = setv[i] | (fl[i] & !clr);
            if (setv[i] || !nfl[i]) sn[i] = 1'b0;
            else if (sel && rd && fl[i]) sn[i] = 1'b1;
        end
        fl = nfl;
        if (apu) begin
            mp[(head + fill) % 16] = pp;
            mf[(head + fill) % 16] = pf;
        end
        if (apo) head = (head + 1) % 16;
        fill = fill + int'(apu) - int'(apo);
    endtask

    // Called at a falling edge: drive, advance model, check after the next rising edge.
    task automatic cyc(input bit pu, input bit pp, input bit pf, input bit po,
                       input logic [5:0] hs, input bit rd, input bit wr,
                       input logic [15:0] wd, input logic [3:0] a, input string req);
        fifo_push = pu; fifo_push_perr = pp; fifo_push_ferr = pf; fifo_pop = po;
        flag_set = hs; reg_rd = rd; reg_wr = wr; reg_wdata = wd; reg_addr = a;
        if (a != 4'(ST)) begin
            #1 check(reg_rdata, 16'h0000, "R12 foreign address reads 0");
        end
        model(pu, pp, pf, po, hs, rd, wr, wd, a == 4'(ST));
        @(posedge clk);
        #1;
        fifo_push = 0; fifo_pop = 0; flag_set = '0; reg_rd = 0; reg_wr = 0;
        reg_addr = 4'(ST);
        #1 check(reg_rdata, exp_word(), req);
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        cyc(0, 0, 0, 0, 6'd0, 0, 0, 16'h0, 4'(ST), req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1 check(reg_rdata, 16'h0060, "R1 reset value");
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1 after release");
        check(reg_rdata, 16'h0060, "R1 constant");
        // Writes of 1 never set; read-only fields ignore writes
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'hFFFF, 4'(ST), "R6 write ones");
        check(reg_rdata, 16'h0060, "R8 read-only fields unchanged");
        // Clear without prior read has no effect
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST), "R7 clear without read");
        check(reg_rdata, 16'h0060, "R7 flags kept");
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST), "R7 read arms");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST), "R7 clear after read");
        check(reg_rdata, 16'h0000, "R7 flags cleared");
        // Hardware set
        cyc(0, 0, 0, 0, 6'b000100, 0, 0, 16'h0, 4'(ST), "R11 break set");
        check(reg_rdata, 16'h0010, "R11 bit 4 set");
        // Set between read and write re-arms the handshake
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST), "R9 read");
        cyc(0, 0, 0, 0, 6'b000100, 0, 0, 16'h0, 4'(ST), "R9 set again");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST), "R9 stale clear");
        check(reg_rdata, 16'h0010, "R9 flag survives stale clear");
        // Set in the same cycle as a valid clear
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST), "R9 read");
        cyc(0, 0, 0, 0, 6'b000100, 0, 1, 16'h0000, 4'(ST), "R9 set beats clear");
        check(reg_rdata, 16'h0010, "R9 set wins");
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST), "R7 read");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'hFFEF, 4'(ST), "R7 clear break only");
        check(reg_rdata, 16'h0000, "R7 break cleared");
        // Foreign address: read does not arm, write does not clear
        cyc(0, 0, 0, 0, 6'b000001, 0, 0, 16'h0, 4'(ST), "R11 data-ready set");
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST + 1), "R12 foreign read");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST), "R12 clear not armed");
        check(reg_rdata, 16'h0001, "R12 flag kept");
        cyc(0, 0, 0, 0, 6'd0, 1, 0, 16'h0, 4'(ST), "R7 read");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST + 2), "R12 foreign write");
        check(reg_rdata, 16'h0001, "R12 foreign write ignored");
        cyc(0, 0, 0, 0, 6'd0, 0, 1, 16'h0000, 4'(ST), "R7 clear");
        // Push and pop with the same tag in one cycle
        cyc(1, 1, 0, 0, 6'd0, 0, 0, 16'h0, 4'(ST), "R10 parity push sets summary");
        check(reg_rdata & 16'hF084, 16'h1084, "R10 count 1 summary head");
        cyc(1, 1, 0, 1, 6'd0, 0, 0, 16'h0, 4'(ST), "R4 push pop same tag");
        check(reg_rdata[15:12], 4'h1, "R4 count unchanged");
        cyc(0, 0, 0, 1, 6'd0, 0, 0, 16'h0, 4'(ST), "R5 drain");
        check(reg_rdata & 16'hFF0C, 16'h0000, "R5 empty head reads 0");
        cyc(0, 0, 0, 1, 6'd0, 0, 0, 16'h0, 4'(ST), "R4 pop empty ignored");
        // Fill with 16 parity entries
        for (int k = 0; k < 16; k++)
            cyc(1, 1, k[0], 0, 6'd0, 0, 0, 16'h0, 4'(ST), "R2 filling");
        check(reg_rdata[15:8], 8'h08, "R3 full parity count reads 0");
        cyc(1, 0, 1, 0, 6'd0, 0, 0, 16'h0, 4'(ST), "R4 push full ignored");
        check(reg_rdata[11:8], 4'h8, "R4 framing count unchanged");
        cyc(0, 0, 0, 1, 6'd0, 0, 0, 16'h0, 4'(ST), "R2 pop one");
        check(reg_rdata[15:12], 4'hF, "R2 count 15");
        for (int k = 0; k < 16; k++)
            cyc(0, 0, 0, 1, 6'd0, 0, 0, 16'h0, 4'(ST), "R5 draining");
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] a = ($urandom % 8 == 0) ? 4'($urandom) : 4'(ST);
            logic [5:0] hs = ($urandom % 6 == 0) ? 6'(1 << ($urandom % 6)) : 6'd0;
            cyc($urandom % 2, $urandom % 3 == 0, $urandom % 4 == 0, $urandom % 2,
                hs, $urandom % 3 == 0, $urandom % 4 == 0, 16'($urandom), a,
                "R2 R5 R7 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule